// File: doc/BRIEF.md
# Four-Channel Interval Timer

This block holds four independent down-counting timer channels that advance only on a 1 MHz tick enable supplied from outside. Each channel is armed through its load/control register with an enable flag, a mode flag and a 29-bit count. It counts down once per tick. When the count has passed through zero it raises a level interrupt. In one-shot mode the channel then disarms itself. In periodic mode it reloads and keeps firing.

Software reaches the channels through a simple synchronous register port. A write takes effect at the clock edge where `wr_en` is high. Reads are combinational from `addr`. Each channel occupies an 8-byte slot at a fixed base. The slot holds the load/control register at +0 and the status/clear register at +4. The interrupt stays high until software writes the clear bit.

Top module: `itimer_quad`

## Requirements
- R1: After synchronous reset every channel is disabled, every `irq` bit is low, and every register reads zero.
- R2: A write at +0 takes bit 31 as enable, bit 30 as periodic select and bits [28:0] as count. Reading +0 returns {enable, periodic, 0, programmed count}.
- R3: Loading count value n−1 with enable set raises the interrupt after exactly n ticks. The count decrements by one per tick and never changes between ticks.
- R4: In one-shot mode (bit 30 = 0), expiry clears the enable bit and the count stays at zero. No further expiry occurs.
- R5: In periodic mode (bit 30 = 1), expiry reloads the programmed count on the same tick, leaves the channel enabled, and the channel fires again after another n ticks.
- R6: Writing 0 to +0 disables the channel. Ticks then change nothing and raise no interrupt.
- R7: Reading +4 returns the live count in bits [28:0] and the pending flag in bit 30. All other bits are zero.
- R8: The interrupt is level-high and stays set until a write to +4 with bit 30 = 1. A write to +4 with bit 30 = 0 has no effect.
- R9: A write to +0 restarts the countdown from the new value at once and leaves an already pending interrupt set.
- R10: Channel bases are 0x00, 0x08, 0x50 and 0x58 for channels 0 to 3. Writes to any other address are ignored, and reads from any other address return zero.
- R11: If a channel expires in the same cycle as a clear write to it, the interrupt stays pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle 1 MHz tick enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte address of register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq | output | 4 | Level interrupt per channel |

## Verification
The hardest case to reach is a collision in a single cycle: a channel expires on exactly the tick that a clear write arrives. A second case is a reload arriving while an interrupt is still pending. The bench counts ticks exactly, so it places the last tick of a countdown in the same clock cycle as the clear write. It also rewrites a channel that has already fired, before clearing that channel. Periodic refire is observed over two full periods, with a clear in between.

// File: rtl/itimer_pkg.sv
package itimer_pkg;
    localparam int NUM_CH  = 4;
    localparam int CNT_W   = 29;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int EN_BIT  = 31;
    localparam int PER_BIT = 30;
    localparam int PND_BIT = 30;

    typedef logic [CNT_W-1:0] count_t;

    typedef struct packed {
        logic   en;
        logic   per;
        count_t reload;
        count_t cnt;
        logic   pend;
    } chan_state_t;

    function automatic logic [ADDR_W-1:0] chan_base(input int idx);
        case (idx)
            0:       chan_base = 8'h00;
            1:       chan_base = 8'h08;
            2:       chan_base = 8'h50;
            default: chan_base = 8'h58;
        endcase
    endfunction
endpackage

// File: rtl/itimer_decode.sv
module itimer_decode
    import itimer_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_CH-1:0] hit,
    output logic              stat_sel
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
        localparam logic [ADDR_W-1:0] BASE = chan_base(i);
        assign hit[i] = (addr[ADDR_W-1:3] == BASE[ADDR_W-1:3]) && (addr[1:0] == 2'b00);
    end
    assign stat_sel = addr[2];

    // R10
    always_comb begin
        hit_onehot_chk: assert ($onehot0(hit));
    end
endmodule

// File: rtl/itimer_chan.sv
module itimer_chan
    import itimer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              ld_we,
    input  logic              ld_en,
    input  logic              ld_per,
    input  count_t            ld_cnt,
    input  logic              clr,
    output logic [DATA_W-1:0] ctrl_rd,
    output logic [DATA_W-1:0] stat_rd,
    output logic              irq
);
    chan_state_t st;
    logic        expire;

    assign expire = tick && st.en && !ld_we && (st.cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            if (ld_we) begin
                st.en     <= ld_en;
                st.per    <= ld_per;
                st.reload <= ld_cnt;
                st.cnt    <= ld_cnt;
            end else if (tick && st.en) begin
                if (st.cnt == '0) begin
                    if (st.per) st.cnt <= st.reload;
                    else        st.en  <= 1'b0;
                end else begin
                    st.cnt <= st.cnt - 1'b1;
                end
            end
            if (expire)   st.pend <= 1'b1;
            else if (clr) st.pend <= 1'b0;
        end
    end

    assign ctrl_rd = {st.en, st.per, 1'b0, st.reload};
    assign stat_rd = {1'b0, st.pend, 1'b0, st.cnt};
    assign irq     = st.pend;

    // R8
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        st.pend && !clr |=> st.pend);
    // R6
    idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !st.en && !ld_we |=> $stable(st.cnt) && !$rose(st.pend));
    // R4
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
        expire && !st.per |=> !st.en && st.pend);
    // R5
    periodic_reload_chk: assert property (@(posedge clk) disable iff (rst)
        expire && st.per |=> st.en && st.cnt == $past(st.reload));
    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        expire && clr |=> st.pend);
    // R3
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick && !ld_we |=> $stable(st.cnt));
endmodule

// File: rtl/itimer_quad.sv
module itimer_quad
    import itimer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NUM_CH-1:0] irq
);
    logic [NUM_CH-1:0] hit;
    logic              stat_sel;
    logic [DATA_W-1:0] ch_rd [NUM_CH];
    logic              unused_wbit;

    assign unused_wbit = wdata[29];

    itimer_decode u_dec (
        .addr     (addr),
        .hit      (hit),
        .stat_sel (stat_sel)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic [DATA_W-1:0] c_rd, s_rd;
        itimer_chan u_chan (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick_en),
            .ld_we   (wr_en && hit[i] && !stat_sel),
            .ld_en   (wdata[EN_BIT]),
            .ld_per  (wdata[PER_BIT]),
            .ld_cnt  (wdata[CNT_W-1:0]),
            .clr     (wr_en && hit[i] && stat_sel && wdata[PND_BIT]),
            .ctrl_rd (c_rd),
            .stat_rd (s_rd),
            .irq     (irq[i])
        );
        assign ch_rd[i] = !hit[i] ? '0 : (stat_sel ? s_rd : c_rd);
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++) rdata |= ch_rd[i];
    end

    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        hit == '0 |-> rdata == '0);
endmodule

// File: tb/itimer_quad_test.sv
module itimer_quad_test;
    logic        clk = 0;
    logic        rst = 1;
    logic        tick_en = 0;
    logic        wr_en = 0;
    logic [7:0]  addr = 0;
    logic [31:0] wdata = 0;
    logic [31:0] rdata;
    logic [3:0]  irq;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    itimer_quad uut (.clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en),
                     .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; #1 d = rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1;
            @(negedge clk); tick_en = 0;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 irq", {28'h0, irq}, 32'h0);
        rd(8'h00, v); check("R1 ctrl", v, 32'h0);
        rd(8'h5c, v); check("R1 stat", v, 32'h0);
    endtask

    task automatic t_oneshot();
        logic [31:0] v;
        wr(8'h08, 32'h8000_0004);
        rd(8'h08, v); check("R2 readback", v, 32'h8000_0004);
        ticks(4);
        rd(8'h0c, v); check("R3 count after 4", v, 32'h0);
        check("R3 no irq yet", {28'h0, irq}, 32'h0);
        ticks(1);
        check("R3 irq after 5", {28'h0, irq}, 32'h2);
        rd(8'h08, v); check("R4 enable dropped", v, 32'h0000_0004);
        rd(8'h0c, v); check("R7 status", v, 32'h4000_0000);
        wr(8'h0c, 32'hBFFF_FFFF);
        check("R8 clear bit not set", {28'h0, irq}, 32'h2);
        wr(8'h0c, 32'h4000_0000);
        check("R8 cleared", {28'h0, irq}, 32'h0);
        ticks(3);
        check("R4 no refire", {28'h0, irq}, 32'h0);
        wr(8'h08, 32'h8000_0000);
        ticks(1);
        check("R3 load zero one tick", {28'h0, irq}, 32'h2);
        wr(8'h0c, 32'h4000_0000);
    endtask

    task automatic t_periodic();
        logic [31:0] v;
        wr(8'h50, 32'hC000_0002);
        ticks(2);
        check("R5 not yet", {28'h0, irq}, 32'h0);
        ticks(1);
        check("R5 first fire", {28'h0, irq}, 32'h4);
        rd(8'h54, v); check("R5 reloaded", v, 32'h4000_0002);
        rd(8'h50, v); check("R5 still enabled", v, 32'hC000_0002);
        wr(8'h54, 32'h4000_0000);
        ticks(2);
        check("R5 cleared between", {28'h0, irq}, 32'h0);
        ticks(1);
        check("R5 second fire", {28'h0, irq}, 32'h4);
        wr(8'h50, 32'h0);
        wr(8'h54, 32'h4000_0000);
    endtask

    task automatic t_disable();
        logic [31:0] v;
        wr(8'h58, 32'h8000_0010);
        ticks(2);
        rd(8'h5c, v); check("R3 decrement", v, 32'h0000_000e);
        wr(8'h58, 32'h0);
        ticks(20);
        check("R6 no irq", {28'h0, irq}, 32'h0);
        rd(8'h5c, v); check("R6 count held", v, 32'h0);
        rd(8'h58, v); check("R6 ctrl zero", v, 32'h0);
    endtask

    task automatic t_restart();
        logic [31:0] v;
        wr(8'h00, 32'h8000_0005);
        ticks(3);
        rd(8'h04, v); check("R9 before", v, 32'h0000_0002);
        wr(8'h00, 32'h8000_0009);
        rd(8'h04, v); check("R9 restarted", v, 32'h0000_0009);
        wr(8'h00, 32'h8000_0000);
        ticks(1);
        wr(8'h00, 32'h8000_0007);
        check("R9 pend kept", {28'h0, irq}, 32'h1);
        rd(8'h04, v); check("R9 status", v, 32'h4000_0007);
        wr(8'h04, 32'h4000_0000);
        wr(8'h00, 32'h0);
    endtask

    task automatic t_map();
        logic [31:0] v;
        wr(8'h10, 32'h8000_0000);
        wr(8'h4c, 32'h8000_0000);
        rd(8'h10, v); check("R10 unmapped read", v, 32'h0);
        ticks(2);
        check("R10 unmapped write", {28'h0, irq}, 32'h0);
        rd(8'h00, v); check("R10 ch0 untouched", v, 32'h0);
        rd(8'h58, v); check("R10 ch3 untouched", v, 32'h0);
    endtask

    task automatic t_collide();
        wr(8'h00, 32'h8000_0000);
        @(negedge clk); tick_en = 1; wr_en = 1; addr = 8'h04; wdata = 32'h4000_0000;
        @(negedge clk); tick_en = 0; wr_en = 0;
        check("R11 set wins", {28'h0, irq}, 32'h1);
        wr(8'h04, 32'h4000_0000);
        check("R11 later clear", {28'h0, irq}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_oneshot();
        t_periodic();
        t_disable();
        t_restart();
        t_map();
        t_collide();
        done = 1;
    end

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule